// File: doc/BRIEF.md
# Effective Address Translation Front End

This block turns a 32-bit effective address, issued for either an instruction fetch or a data access, into a physical address. When relocation is switched off for the access type, the address passes straight through. When relocation is on, the address is checked in parallel against a bank of block translation entries for that access type. There are four entries for fetches and four for data, by default. Each entry covers a power-of-two-sized, aligned region of 128 KB or larger. A single match yields the physical address together with the entry's memory attributes and protection bits. More than one match is reported as an error.

On a miss, the top nibble of the effective address picks one of sixteen segment descriptors. A descriptor flagged as direct-store raises a storage fault, which is reported on the instruction or data side according to the access. Any other descriptor forms a 52-bit virtual address and raises a request for a page-table walk. The walk itself is done elsewhere.

The translation tables are loaded through a simple write port. Each request is answered exactly one clock later by a registered result.

Top module: `addr_xlate`

## Requirements
- R1: When the relocation bit for the access type is 0 (`instrReloc` for fetches, `dataReloc` for data), the result has `hit`=1, `physAddr` equal to `effAddr`, and `attr`, `prot` and `attrErr` all 0. The other access type's relocation bit has no effect.
- R2: `rspValid` is 1 exactly one cycle after a cycle with `reqValid`=1. After a cycle with `reqValid`=0, `rspValid` and all result flags are 0.
- R3: The translation entry set is selected by the access type: fetches use entries 0..NUM_BAT-1 and data accesses use the data set. An entry matches when `effAddr[31:17]` equals the entry's page index in every bit position not covered by the length mask. It also needs its valid bit for the current mode: user valid when `userMode`=1, supervisor valid otherwise.
- R4: On a single match, `physAddr[31:28]` comes from the entry's physical page and `physAddr[16:0]` from `effAddr[16:0]`. Each bit of `physAddr[27:17]` comes from `effAddr` where the length mask bit is 1 and from the physical page where it is 0.
- R5: Two or more matches give `multiHitErr`=1 with `hit`=0 and `physAddr`=0. A match takes priority over the segment path.
- R6: With no match, the segment descriptor indexed by `effAddr[31:28]` is used. If its direct-store bit (word bit 31) is 1, the result is `instrFault`=1 for a fetch or `dataFault`=1 for a data access.
- R7: With no match and a segment whose direct-store bit is 0, the result is `walkReq`=1 and `virtAddr` = {segment word bits 23:0, `effAddr[27:0]`}. Otherwise `virtAddr` is 0.
- R8: On a single match, `attr` and `prot` carry the entry's lower-word bits 6:3 and 1:0. `attrErr` is 1 when `attr[3]` and `attr[2]` are both 1, an invalid combination. The translation itself still completes.
- R9: Configuration words are written when `cfgWrEn`=1 at index `cfgWrIdx`, and writes with `cfgWrEn`=0 are ignored. The indices are laid out as follows:
  - index = set*2*NUM_BAT + 2*entry + word, with set 0 for fetch, set 1 for data, word 0 for upper and word 1 for lower;
  - segments follow at 4*NUM_BAT + nibble.
  - Upper word: page index in bits 31:17, length mask in bits 12:2, supervisor valid in bit 1, user valid in bit 0.
  - Lower word: physical page in bits 31:17.
- R10: Reset clears all entries, all segment descriptors and all outputs. After reset every entry is invalid and every segment is a non-direct-store segment with identifier 0.
- R11: Exactly one of `hit`, `multiHitErr`, `instrFault`, `dataFault`, `walkReq` is 1 whenever `rspValid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrIdx | input | IDX_W (5) | Configuration word index |
| cfgWrData | input | 32 | Configuration word |
| reqValid | input | 1 | Translation request |
| effAddr | input | 32 | Effective address |
| isFetch | input | 1 | 1 for instruction fetch, 0 for data access |
| instrReloc | input | 1 | Relocation enable for fetches |
| dataReloc | input | 1 | Relocation enable for data |
| userMode | input | 1 | 1 when in user (problem) state |
| rspValid | output | 1 | Result valid |
| hit | output | 1 | Translated (real mode or single match) |
| physAddr | output | 32 | Physical address |
| attr | output | 4 | Memory attributes from matching entry |
| prot | output | 2 | Protection bits from matching entry |
| attrErr | output | 1 | Invalid attribute combination |
| multiHitErr | output | 1 | More than one entry matched |
| instrFault | output | 1 | Direct-store segment on a fetch |
| dataFault | output | 1 | Direct-store segment on a data access |
| walkReq | output | 1 | Page-table walk needed |
| virtAddr | output | 52 | Virtual address for the walk |

## Verification
The assertions check the following on every cycle:
- the one-cycle request-to-result timing;
- exactly one outcome per result;
- the real-mode identity;
- the page offset kept through a match;
- the side on which a storage fault is raised;
- the low bits of the walk address;
- that an attribute error only appears on a real match.

Other behaviour depends on the loaded table contents, so only the bench's scenarios can show it:
- which entry set is consulted;
- the mode-dependent valid bits;
- the masked compare and the splice of page and offset;
- overlapping entries;
- segment selection by nibble;
- ignored writes.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int EA_W     = 32;
  localparam int EPI_W    = 15;   // effAddr[31:17]
  localparam int MASK_W   = 11;   // masks effAddr[27:17]
  localparam int ATTR_W   = 4;
  localparam int PROT_W   = 2;
  localparam int VSID_W   = 24;
  localparam int SEG_CNT  = 16;
  localparam int SEGOFF_W = 28;
  localparam int VA_W     = VSID_W + SEGOFF_W;

  typedef struct packed {
    logic [EPI_W-1:0]  epi;
    logic [MASK_W-1:0] lenMask;
    logic              supV;
    logic              usrV;
  } batUpper_t;

  typedef struct packed {
    logic [EPI_W-1:0]  ppn;
    logic [ATTR_W-1:0] attr;
    logic [PROT_W-1:0] prot;
  } batLower_t;

  typedef struct packed {
    logic              direct;
    logic [VSID_W-1:0] vsid;
  } segDesc_t;

  typedef struct packed {
    logic useReal;
    logic useBat;
    logic multiHit;
    logic dsFault;
    logic walk;
  } xlateStrobe_t;

  function automatic batUpper_t toUpper(input logic [EA_W-1:0] w);
    return '{epi: w[31:17], lenMask: w[12:2], supV: w[1], usrV: w[0]};
  endfunction

  function automatic batLower_t toLower(input logic [EA_W-1:0] w);
    return '{ppn: w[31:17], attr: w[6:3], prot: w[1:0]};
  endfunction

  function automatic segDesc_t toSeg(input logic [EA_W-1:0] w);
    return '{direct: w[31], vsid: w[23:0]};
  endfunction
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int NUM_BAT = 4
) (
  input  logic [NUM_BAT-1:0] batHits,
  input  logic               segDirect,
  input  logic               isFetch,
  input  logic               instrReloc,
  input  logic               dataReloc,
  output xlateStrobe_t       strb
);
  localparam int CNT_W = $clog2(NUM_BAT + 1);

  logic [CNT_W-1:0] hitCnt;
  logic             relocOn;

  always_comb begin
    hitCnt = '0;
    for (int i = 0; i < NUM_BAT; i++) hitCnt = hitCnt + CNT_W'(batHits[i]);
  end

  assign relocOn = isFetch ? instrReloc : dataReloc;

  // Priority: real mode, then entry match (single or multiple), then segment path.
  always_comb begin
    strb          = '0;
    strb.useReal  = !relocOn;
    strb.multiHit = relocOn && (hitCnt > CNT_W'(1));
    strb.useBat   = relocOn && (hitCnt == CNT_W'(1));
    strb.dsFault  = relocOn && (hitCnt == '0) && segDirect;
    strb.walk     = relocOn && (hitCnt == '0) && !segDirect;
  end
endmodule

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int NUM_BAT = 4,
  parameter int IDX_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [IDX_W-1:0]    cfgWrIdx,
  input  logic [EA_W-1:0]     cfgWrData,
  input  logic                reqValid,
  input  logic [EA_W-1:0]     effAddr,
  input  logic                isFetch,
  input  logic                userMode,
  input  xlateStrobe_t        strb,
  output logic [NUM_BAT-1:0]  batHits,
  output logic                segDirect,
  output logic                rspValidQ,
  output logic                hitQ,
  output logic [EA_W-1:0]     physAddrQ,
  output logic [ATTR_W-1:0]   attrQ,
  output logic [PROT_W-1:0]   protQ,
  output logic                attrErrQ,
  output logic                multiHitQ,
  output logic                instrFaultQ,
  output logic                dataFaultQ,
  output logic                walkQ,
  output logic [VA_W-1:0]     virtAddrQ
);
  localparam int ENTRIES  = 2 * NUM_BAT;     // both sets
  localparam int BAT_REGS = 2 * ENTRIES;     // upper + lower words

  batUpper_t batUp [ENTRIES];
  batLower_t batLo [ENTRIES];
  segDesc_t  segs  [SEG_CNT];

  // Configuration storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        batUp[i] <= '0;
        batLo[i] <= '0;
      end
      for (int s = 0; s < SEG_CNT; s++) segs[s] <= '0;
    end else if (cfgWrEn) begin
      for (int i = 0; i < BAT_REGS; i++) begin
        if (cfgWrIdx == IDX_W'(i)) begin
          if (i % 2 == 0) batUp[i/2] <= toUpper(cfgWrData);
          else            batLo[i/2] <= toLower(cfgWrData);
        end
      end
      for (int s = 0; s < SEG_CNT; s++)
        if (cfgWrIdx == IDX_W'(BAT_REGS + s)) segs[s] <= toSeg(cfgWrData);
    end
  end

  // Parallel compare, one lane per entry of the selected set
  logic [EA_W-1:0]   paVec   [NUM_BAT];
  logic [ATTR_W-1:0] attrVec [NUM_BAT];
  logic [PROT_W-1:0] protVec [NUM_BAT];

  for (genvar g = 0; g < NUM_BAT; g++) begin : g_lane
    batUpper_t             up;
    batLower_t             lo;
    logic                  modeOk;
    logic [EPI_W-1:0]      cmpMask;
    assign up      = isFetch ? batUp[g] : batUp[NUM_BAT + g];
    assign lo      = isFetch ? batLo[g] : batLo[NUM_BAT + g];
    assign modeOk  = userMode ? up.usrV : up.supV;
    assign cmpMask = ~{{(EPI_W-MASK_W){1'b0}}, up.lenMask};
    assign batHits[g] = modeOk &&
      ((effAddr[31:17] & cmpMask) == (up.epi & cmpMask));
    assign paVec[g] = {lo.ppn[EPI_W-1:MASK_W],
                       (lo.ppn[MASK_W-1:0] & ~up.lenMask) | (effAddr[27:17] & up.lenMask),
                       effAddr[16:0]};
    assign attrVec[g] = lo.attr;
    assign protVec[g] = lo.prot;
  end

  logic [EA_W-1:0]   selPa;
  logic [ATTR_W-1:0] selAttr;
  logic [PROT_W-1:0] selProt;

  always_comb begin
    selPa   = '0;
    selAttr = '0;
    selProt = '0;
    for (int i = 0; i < NUM_BAT; i++) begin
      if (batHits[i]) begin
        selPa   = selPa | paVec[i];
        selAttr = selAttr | attrVec[i];
        selProt = selProt | protVec[i];
      end
    end
  end

  segDesc_t curSeg;
  assign curSeg    = segs[effAddr[31:28]];
  assign segDirect = curSeg.direct;

  // Result register: one cycle of latency
  always_ff @(posedge clk) begin
    if (!rstN || !reqValid) begin
      rspValidQ   <= 1'b0;
      hitQ        <= 1'b0;
      physAddrQ   <= '0;
      attrQ       <= '0;
      protQ       <= '0;
      attrErrQ    <= 1'b0;
      multiHitQ   <= 1'b0;
      instrFaultQ <= 1'b0;
      dataFaultQ  <= 1'b0;
      walkQ       <= 1'b0;
      virtAddrQ   <= '0;
    end else begin
      rspValidQ   <= 1'b1;
      hitQ        <= strb.useReal | strb.useBat;
      physAddrQ   <= strb.useReal ? effAddr : (strb.useBat ? selPa : '0);
      attrQ       <= strb.useBat ? selAttr : '0;
      protQ       <= strb.useBat ? selProt : '0;
      attrErrQ    <= strb.useBat & selAttr[3] & selAttr[2];
      multiHitQ   <= strb.multiHit;
      instrFaultQ <= strb.dsFault & isFetch;
      dataFaultQ  <= strb.dsFault & ~isFetch;
      walkQ       <= strb.walk;
      virtAddrQ   <= strb.walk ? {curSeg.vsid, effAddr[SEGOFF_W-1:0]} : '0;
    end
  end

  // R11: one outcome per result
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValidQ |-> $onehot({hitQ, multiHitQ, instrFaultQ, dataFaultQ, walkQ}));
  // R6: fault side follows the access type of the request
  p_ifault_side_r6: assert property (@(posedge clk) disable iff (!rstN)
    instrFaultQ |-> $past(isFetch));
  p_dfault_side_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataFaultQ |-> !$past(isFetch));
  // R7: walk address keeps the segment offset
  p_walk_offset_r7: assert property (@(posedge clk) disable iff (!rstN)
    walkQ |-> virtAddrQ[SEGOFF_W-1:0] == $past(effAddr[SEGOFF_W-1:0]));
  // R4: page offset passes through any translation
  p_page_offset_r4: assert property (@(posedge clk) disable iff (!rstN)
    hitQ |-> physAddrQ[16:0] == $past(effAddr[16:0]));
  // R8: attribute error only on a translated result with both bits set
  p_attr_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    attrErrQ |-> (hitQ && attrQ[3] && attrQ[2]));
  // R5: multiple match yields no address
  p_multi_noaddr_r5: assert property (@(posedge clk) disable iff (!rstN)
    multiHitQ |-> (!hitQ && physAddrQ == '0));
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
  import xlate_pkg::*;
#(
  parameter  int NUM_BAT = 4,
  localparam int IDX_W   = $clog2(4 * NUM_BAT + SEG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgWrIdx,
  input  logic [31:0]       cfgWrData,
  input  logic              reqValid,
  input  logic [31:0]       effAddr,
  input  logic              isFetch,
  input  logic              instrReloc,
  input  logic              dataReloc,
  input  logic              userMode,
  output logic              rspValid,
  output logic              hit,
  output logic [31:0]       physAddr,
  output logic [3:0]        attr,
  output logic [1:0]        prot,
  output logic              attrErr,
  output logic              multiHitErr,
  output logic              instrFault,
  output logic              dataFault,
  output logic              walkReq,
  output logic [51:0]       virtAddr
);
  xlateStrobe_t       strb;
  logic [NUM_BAT-1:0] batHits;
  logic               segDirect;

  xlate_ctrl #(.NUM_BAT(NUM_BAT)) u_ctrl (
    .batHits(batHits), .segDirect(segDirect), .isFetch(isFetch),
    .instrReloc(instrReloc), .dataReloc(dataReloc), .strb(strb)
  );

  xlate_dp #(.NUM_BAT(NUM_BAT), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx),
    .cfgWrData(cfgWrData), .reqValid(reqValid), .effAddr(effAddr),
    .isFetch(isFetch), .userMode(userMode), .strb(strb),
    .batHits(batHits), .segDirect(segDirect),
    .rspValidQ(rspValid), .hitQ(hit), .physAddrQ(physAddr), .attrQ(attr),
    .protQ(prot), .attrErrQ(attrErr), .multiHitQ(multiHitErr),
    .instrFaultQ(instrFault), .dataFaultQ(dataFault), .walkQ(walkReq),
    .virtAddrQ(virtAddr)
  );

  // R2: one-cycle latency and idle clearing
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !hit && !walkReq));
  // R1: real mode is identity
  p_real_identity_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !(isFetch ? instrReloc : dataReloc)) |=>
      (hit && physAddr == $past(effAddr) && attr == '0));
endmodule

// File: tb/addr_xlate_test.sv
module addr_xlate_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [4:0]  cfgWrIdx;
  logic [31:0] cfgWrData;
  logic        reqValid;
  logic [31:0] effAddr;
  logic        isFetch, instrReloc, dataReloc, userMode;
  logic        rspValid, hit, attrErr, multiHitErr, instrFault, dataFault, walkReq;
  logic [31:0] physAddr;
  logic [3:0]  attr;
  logic [1:0]  prot;
  logic [51:0] virtAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  addr_xlate uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx),
    .cfgWrData(cfgWrData), .reqValid(reqValid), .effAddr(effAddr),
    .isFetch(isFetch), .instrReloc(instrReloc), .dataReloc(dataReloc),
    .userMode(userMode), .rspValid(rspValid), .hit(hit), .physAddr(physAddr),
    .attr(attr), .prot(prot), .attrErr(attrErr), .multiHitErr(multiHitErr),
    .instrFault(instrFault), .dataFault(dataFault), .walkReq(walkReq),
    .virtAddr(virtAddr)
  );

  // outcome code: 0 hit, 1 multiple match, 2 fetch fault, 3 data fault, 4 walk
  typedef struct packed {
    logic [31:0] ea;
    logic        f, ir, dr, usr;
    logic [2:0]  oc;
    logic [31:0] pa;
    logic [51:0] va;
    logic [3:0]  at;
    logic [1:0]  pr;
    logic        ae;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h12345678, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h12345678, 52'h0, 4'h0, 2'd0, 1'b0, 8'd1},
    '{32'hDEADBEEC, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 32'hDEADBEEC, 52'h0, 4'h0, 2'd0, 1'b0, 8'd1},
    '{32'h801F1234, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 32'h0ABF1234, 52'h0, 4'h0, 2'd2, 1'b0, 8'd4},
    '{32'h801F1234, 1'b1, 1'b1, 1'b1, 1'b1, 3'd4, 32'h0, 52'h00000001F1234, 4'h0, 2'd0, 1'b0, 8'd3},
    '{32'h801F1234, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 32'h001F1234, 52'h0, 4'h2, 2'd2, 1'b0, 8'd3},
    '{32'hC0000100, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 32'h0, 52'h0, 4'h0, 2'd0, 1'b0, 8'd5},
    '{32'hC1234560, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 32'h01234560, 52'h0, 4'hC, 2'd1, 1'b1, 8'd8},
    '{32'h40010004, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 32'h12310004, 52'h0, 4'h0, 2'd3, 1'b0, 8'd4},
    '{32'h40010004, 1'b0, 1'b1, 1'b1, 1'b0, 3'd3, 32'h0, 52'h0, 4'h0, 2'd0, 1'b0, 8'd6},
    '{32'h40000000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd2, 32'h0, 52'h0, 4'h0, 2'd0, 1'b0, 8'd6},
    '{32'h17654321, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4, 32'h0, 52'hABCDEF7654321, 4'h0, 2'd0, 1'b0, 8'd7},
    '{32'hC0000100, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'hC0000100, 52'h0, 4'h0, 2'd0, 1'b0, 8'd1}
  };

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [4:0] idx, input logic [31:0] data, input logic en);
    @(negedge clk);
    cfgWrEn = en; cfgWrIdx = idx; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // drive a request at a falling edge, sample one falling edge later
  task automatic request(input logic [31:0] ea, input logic f, ir, dr, usr);
    @(negedge clk);
    reqValid = 1'b1; effAddr = ea; isFetch = f;
    instrReloc = ir; dataReloc = dr; userMode = usr;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  function automatic logic [126:0] packResult();
    return {rspValid, hit, multiHitErr, instrFault, dataFault, walkReq,
            physAddr, virtAddr, attr, prot, attrErr};
  endfunction

  function automatic logic [126:0] packExpect(input vec_t v);
    logic [4:0] flags;
    flags = 5'b10000 >> v.oc;
    return {1'b1, flags, v.pa, v.va, v.at, v.pr, v.ae};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgWrIdx = '0; cfgWrData = '0;
    reqValid = 1'b0; effAddr = '0; isFetch = 1'b0;
    instrReloc = 1'b0; dataReloc = 1'b0; userMode = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state of outputs
    check(!rspValid && !hit && physAddr == 0 && virtAddr == 0 && !walkReq,
          "R10 reset outputs", 128'(packResult()), 128'h0);
    rstN = 1'b1;

    // R9: load tables (fetch entry 0, data entries 0..3, segments 4 and 1)
    cfgWrite(5'd0,  32'h8000003E, 1'b1);
    cfgWrite(5'd1,  32'h0AA00002, 1'b1);
    cfgWrite(5'd8,  32'h80001FFF, 1'b1);
    cfgWrite(5'd9,  32'h00000012, 1'b1);
    cfgWrite(5'd10, 32'hC0001FFF, 1'b1);
    cfgWrite(5'd11, 32'h00000061, 1'b1);
    cfgWrite(5'd12, 32'hC0000003, 1'b1);
    cfgWrite(5'd13, 32'h01000000, 1'b1);
    cfgWrite(5'd14, 32'h40000001, 1'b1);
    cfgWrite(5'd15, 32'h12300003, 1'b1);
    cfgWrite(5'd20, 32'h80000000, 1'b1);
    cfgWrite(5'd17, 32'h00ABCDEF, 1'b1);

    // table walk: R1 R3 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < NV; i++) begin
      request(VECS[i].ea, VECS[i].f, VECS[i].ir, VECS[i].dr, VECS[i].usr);
      check(packResult() == packExpect(VECS[i]),
            $sformatf("R%0d vector %0d", VECS[i].rq, i),
            128'(packResult()), 128'(packExpect(VECS[i])));
    end

    // R2: idle cycle after a request clears the result
    @(negedge clk);
    check(!rspValid && !hit && !walkReq && !multiHitErr, "R2 idle cycle",
          128'(packResult()), 128'h0);

    // R2: back-to-back requests each answered next cycle
    @(negedge clk);
    reqValid = 1'b1; effAddr = 32'h00000040; isFetch = 1'b0;
    instrReloc = 1'b0; dataReloc = 1'b0; userMode = 1'b0;
    @(negedge clk);
    check(rspValid && physAddr == 32'h00000040, "R2 first of pair",
          128'(physAddr), 128'h40);
    effAddr = 32'h00000080;
    @(negedge clk);
    check(rspValid && physAddr == 32'h00000080, "R2 second of pair",
          128'(physAddr), 128'h80);
    reqValid = 1'b0;

    // R9: write with enable low is ignored
    cfgWrite(5'd17, 32'h00111111, 1'b0);
    request(32'h17654321, 1'b0, 1'b1, 1'b1, 1'b0);
    check(walkReq && virtAddr == 52'hABCDEF7654321, "R9 ignored write",
          128'(virtAddr), 128'h0ABCDEF7654321);

    // R9: enabled write takes effect
    cfgWrite(5'd17, 32'h00111111, 1'b1);
    request(32'h17654321, 1'b0, 1'b1, 1'b1, 1'b0);
    check(walkReq && virtAddr == 52'h1111117654321, "R9 segment rewrite",
          128'(virtAddr), 128'h1111117654321);

    // R3: fetch uses the fetch set, so a data-only region misses
    request(32'hC1234560, 1'b1, 1'b1, 1'b0, 1'b0);
    check(walkReq && !hit, "R3 fetch ignores data set",
          128'(packResult()), 128'h0);

    // R10: reset clears tables
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    request(32'h40010004, 1'b0, 1'b1, 1'b1, 1'b1);
    check(walkReq && !hit && virtAddr == 52'h0000000010004, "R10 tables cleared",
          128'(virtAddr), 128'h10004);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule